// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block walks one vector arithmetic instruction through its elements, one element per clock. For every element it issues, it presents the element number, a valid strobe and a write-enable for the result. The arithmetic datapath and the register file sit outside the block and follow these strobes. The caller supplies three things on a start pulse: an active-length value, a mask-enable flag and a mode bit. In the write-suppress mode every element under the length is issued, and the write-enable drops wherever the mask bit is zero, so those slots become bubbles. In the density mode only elements whose mask bit is set are issued, and the cleared positions cost no cycle at all.

The per-element mask is held inside the block. It is loaded in one cycle from a not-equal compare of every element of a vector against one scalar. A done pulse marks the end of each instruction. A busy output covers the cycles in which elements are being issued.

Top module: `vseq_elem_seq`

## Requirements
- R1: No element number equal to or above the active length captured at start is ever issued. A length above 64 acts as 64, and a length of 0 issues nothing.
- R2: A compare-load (`cmp_load_i` high at an edge while idle and without a start) sets mask bit i to 1 exactly when element i (bits `[i*ELEM_W +: ELEM_W]` of `cmp_elems_i`) differs from `cmp_scalar_i`, and clears it otherwise.
- R3: In write-suppress mode (`dense_i`=0) with masking on, elements 0 up to length-1 are issued in ascending order on consecutive cycles, starting in the cycle after the start edge. The write-enable of each element equals its mask bit.
- R4: In density mode (`dense_i`=1) with masking on, only elements whose mask bit is 1 are issued, in ascending order on consecutive cycles with no gaps, each with the write-enable high.
- R5: With masking off (`mask_en_i`=0), every element below the length is issued and written, whatever the mode bit is.
- R6: `done_o` is a one-cycle pulse in the cycle after the last issued element. When an instruction has nothing to issue (length 0, or density mode with no mask bit set under the length), it comes in the cycle after the start edge.
- R7: A start that arrives while elements are being issued has no effect on the running sequence and does not begin a new one. `busy_o` is high exactly in the cycles in which an element is issued.
- R8: A compare-load presented while busy, or in the same cycle as a start, leaves the mask unchanged.
- R9: After reset, busy, valid and done are low and the mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an instruction; ignored while busy |
| vlen_i | input | 7 | Active vector length, sampled at start |
| mask_en_i | input | 1 | Apply the mask to this instruction, sampled at start |
| dense_i | input | 1 | 1 selects density mode, 0 selects write-suppress mode |
| cmp_load_i | input | 1 | Load the mask from the element compare |
| cmp_elems_i | input | 512 | 64 packed elements for the compare, element 0 in the low bits |
| cmp_scalar_i | input | 8 | Scalar that each element is compared against |
| busy_o | output | 1 | An element is being issued this cycle |
| issue_vld_o | output | 1 | Element issue strobe |
| issue_idx_o | output | 6 | Number of the issued element |
| wr_en_o | output | 1 | Result write-enable for the issued element |
| done_o | output | 1 | Instruction finished pulse |

## Verification
The bench goes after the length edges: a length of 0, a length of exactly 64 and a length above 64. A design that compared the length wrongly would issue one element too many, or would wrap around and run forever. It runs density mode on an all-zero mask and on an all-one mask. A design that got the scan wrong would then either stall with nothing to issue, or issue bubbles and leave gaps between elements. It pokes a start and a compare-load into the middle of a running instruction, where a weak interlock would restart the count or rewrite the mask during the run. Random masks and lengths are mixed into every mode, so that a wrong write-enable polarity, or a mode select that ignores the masking flag, shows up as an element-by-element mismatch.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic {
    RUN_SUPPRESS = 1'b0,
    RUN_DENSE    = 1'b1
  } run_mode_e;
endpackage

// File: rtl/vseq_mask_cmp.sv
module vseq_mask_cmp #(
  parameter int MAX_VL = 64,
  parameter int ELEM_W = 8
) (
  input  logic [MAX_VL*ELEM_W-1:0] elems_i,
  input  logic [ELEM_W-1:0]        scalar_i,
  output logic [MAX_VL-1:0]        ne_o
);
  // one comparator per element slot
  for (genvar g = 0; g < MAX_VL; g++) begin : g_lane
    assign ne_o[g] = (elems_i[g*ELEM_W +: ELEM_W] != scalar_i);
  end
endmodule

// File: rtl/vseq_limit.sv
module vseq_limit #(
  parameter int MAX_VL = 64,
  parameter int VL_W   = 7
) (
  input  logic [VL_W-1:0]   vl_i,
  output logic [VL_W-1:0]   vl_eff_o,
  output logic [MAX_VL-1:0] below_o
);
  localparam logic [VL_W-1:0] VlCap = VL_W'(MAX_VL);

  function automatic logic [VL_W-1:0] clamp_len(input logic [VL_W-1:0] v);
    return (v > VlCap) ? VlCap : v;
  endfunction

  assign vl_eff_o = clamp_len(vl_i);

  for (genvar g = 0; g < MAX_VL; g++) begin : g_bit
    assign below_o[g] = (VL_W'(g) < vl_eff_o);
  end
endmodule

// File: rtl/vseq_pick.sv
module vseq_pick #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6
) (
  input  logic [MAX_VL-1:0] pend_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [MAX_VL-1:0] rest_o
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [MAX_VL-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign found_o = |pend_i;
  assign idx_o   = lowest_set(pend_i);
  assign rest_o  = pend_i & (pend_i - 1'b1);
endmodule

// File: rtl/vseq_elem_seq.sv
module vseq_elem_seq
  import vseq_pkg::*;
#(
  parameter  int MAX_VL = 64,
  parameter  int ELEM_W = 8,
  localparam int IdxW   = $clog2(MAX_VL),
  localparam int VlW    = IdxW + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [VlW-1:0]           vlen_i,
  input  logic                     mask_en_i,
  input  logic                     dense_i,
  input  logic                     cmp_load_i,
  input  logic [MAX_VL*ELEM_W-1:0] cmp_elems_i,
  input  logic [ELEM_W-1:0]        cmp_scalar_i,
  output logic                     busy_o,
  output logic                     issue_vld_o,
  output logic [IdxW-1:0]          issue_idx_o,
  output logic                     wr_en_o,
  output logic                     done_o
);
  logic [MAX_VL-1:0] mask_q, pend_q, pend_rest, cmp_ne, below_vec, start_set;
  logic [VlW-1:0]    vl_eff, vlen_q;
  logic              masked_q, done_q, pick_found;
  logic [IdxW-1:0]   pick_idx;
  run_mode_e         mode_q;

  // named events for the checker
  logic start_acc, mask_load, last_issue;

  vseq_mask_cmp #(.MAX_VL(MAX_VL), .ELEM_W(ELEM_W)) u_cmp (
    .elems_i (cmp_elems_i),
    .scalar_i(cmp_scalar_i),
    .ne_o    (cmp_ne)
  );

  vseq_limit #(.MAX_VL(MAX_VL), .VL_W(VlW)) u_lim (
    .vl_i    (vlen_i),
    .vl_eff_o(vl_eff),
    .below_o (below_vec)
  );

  vseq_pick #(.MAX_VL(MAX_VL), .IDX_W(IdxW)) u_pick (
    .pend_i (pend_q),
    .found_o(pick_found),
    .idx_o  (pick_idx),
    .rest_o (pend_rest)
  );

  assign start_acc  = start_i & ~pick_found;
  assign mask_load  = cmp_load_i & ~pick_found & ~start_i;
  assign last_issue = pick_found & ~(|pend_rest);
  assign start_set  = (dense_i && mask_en_i) ? (below_vec & mask_q) : below_vec;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      pend_q   <= '0;
      vlen_q   <= '0;
      masked_q <= 1'b0;
      mode_q   <= RUN_SUPPRESS;
      done_q   <= 1'b0;
    end else begin
      if (mask_load) mask_q <= cmp_ne;
      if (start_acc) begin
        pend_q   <= start_set;
        vlen_q   <= vl_eff;
        masked_q <= mask_en_i;
        mode_q   <= dense_i ? RUN_DENSE : RUN_SUPPRESS;
      end else begin
        pend_q <= pend_rest;
      end
      done_q <= (start_acc && !(|start_set)) || last_issue;
    end
  end

  assign busy_o      = pick_found;
  assign issue_vld_o = pick_found;
  assign issue_idx_o = pick_idx;
  assign wr_en_o     = pick_found & (~masked_q | mask_q[pick_idx]);
  assign done_o      = done_q;
endmodule

// File: rtl/vseq_elem_seq_chk.sv
module vseq_elem_seq_chk #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6,
  parameter int VL_W   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_vld_o,
  input logic [IDX_W-1:0]  issue_idx_o,
  input logic              wr_en_o,
  input logic              done_o,
  input logic              busy_o,
  input logic [VL_W-1:0]   vlen_q,
  input logic              masked_q,
  input logic              mode_q,
  input logic [MAX_VL-1:0] mask_q
);
  p_idx_below_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o |-> ({1'b0, issue_idx_o} < vlen_q));

  p_ascending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_o && $past(issue_vld_o)) |-> (issue_idx_o > $past(issue_idx_o)));

  p_dense_writes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_o && mode_q && masked_q) |-> wr_en_o);

  p_unmasked_writes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_o && !masked_q) |-> wr_en_o);

  p_done_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(issue_vld_o) |-> done_o);

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !issue_vld_o);

  p_mask_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mask_q));
endmodule

bind vseq_elem_seq vseq_elem_seq_chk #(.MAX_VL(MAX_VL), .IDX_W(IdxW), .VL_W(VlW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .issue_vld_o(issue_vld_o),
  .issue_idx_o(issue_idx_o),
  .wr_en_o    (wr_en_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .vlen_q     (vlen_q),
  .masked_q   (masked_q),
  .mode_q     (mode_q),
  .mask_q     (mask_q)
);

// File: tb/vseq_elem_seq_tb_top.sv
module vseq_elem_seq_tb_top;
  localparam int VL = 64;
  localparam int EW = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i, mask_en_i, dense_i, cmp_load_i;
  logic [6:0]       vlen_i;
  logic [VL*EW-1:0] cmp_elems_i;
  logic [EW-1:0]    cmp_scalar_i;
  logic             busy_o, issue_vld_o, wr_en_o, done_o;
  logic [5:0]       issue_idx_o;

  int errors = 0;
  int checks = 0;
  logic [VL-1:0] mdl_mask;

  always #5 clk = ~clk;

  vseq_elem_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vlen_i(vlen_i),
    .mask_en_i(mask_en_i), .dense_i(dense_i), .cmp_load_i(cmp_load_i),
    .cmp_elems_i(cmp_elems_i), .cmp_scalar_i(cmp_scalar_i),
    .busy_o(busy_o), .issue_vld_o(issue_vld_o), .issue_idx_o(issue_idx_o),
    .wr_en_o(wr_en_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [VL-1:0] ne_of(input logic [VL*EW-1:0] el, input logic [EW-1:0] sc);
    logic [VL-1:0] m;
    for (int i = 0; i < VL; i++) m[i] = (el[i*EW +: EW] != sc);
    return m;
  endfunction

  function automatic logic [VL*EW-1:0] gen_elems(input logic [EW-1:0] sc, input int pct_diff);
    logic [VL*EW-1:0] e;
    for (int i = 0; i < VL; i++) begin
      if (($urandom % 100) < pct_diff) e[i*EW +: EW] = sc ^ EW'(1 + ($urandom % 255));
      else e[i*EW +: EW] = sc;
    end
    return e;
  endfunction

  task automatic load_mask(input logic [VL*EW-1:0] el, input logic [EW-1:0] sc);
    @(negedge clk);
    cmp_elems_i = el; cmp_scalar_i = sc; cmp_load_i = 1'b1;
    @(negedge clk);
    cmp_load_i = 1'b0;
    mdl_mask = ne_of(el, sc);
  endtask

  // one instruction: expected sequence derived from the requirements
  task automatic do_run(input int vl, input bit dn, input bit men,
                        input bit poke_start, input bit poke_load, input string req);
    int eidx[VL];
    bit ewr[VL];
    int n = 0;
    int lim = (vl > VL) ? VL : vl;
    for (int i = 0; i < lim; i++) begin
      if (!(dn && men) || mdl_mask[i]) begin
        eidx[n] = i;
        ewr[n] = !men || mdl_mask[i];
        n++;
      end
    end
    @(negedge clk);
    vlen_i = 7'(vl); dense_i = dn; mask_en_i = men; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(issue_vld_o && busy_o && issue_idx_o == 6'(eidx[k]) && wr_en_o == ewr[k] && !done_o,
          req, $sformatf("element %0d {vld,idx,wr}", k),
          {issue_vld_o, issue_idx_o, wr_en_o}, {1'b1, 6'(eidx[k]), ewr[k]});
      if (k == 1 && poke_start) begin
        start_i = 1'b1; vlen_i = 7'd3; dense_i = ~dn; mask_en_i = ~men;
      end
      if (k == 1 && poke_load) begin
        cmp_elems_i = '1; cmp_scalar_i = '0; cmp_load_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0; cmp_load_i = 1'b0;
    end
    chk(done_o && !issue_vld_o && !busy_o, "R6", {req, " done after last element"},
        {done_o, issue_vld_o, busy_o}, 3'b100);
    @(negedge clk);
    chk(!done_o && !busy_o && !issue_vld_o, poke_start ? "R7" : "R6",
        {req, " done single pulse, idle after"}, {done_o, busy_o, issue_vld_o}, 3'b000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [EW-1:0] sc;
    logic [VL*EW-1:0] el;
    rst_n = 1'b0; start_i = 0; mask_en_i = 0; dense_i = 0; cmp_load_i = 0;
    vlen_i = '0; cmp_elems_i = '0; cmp_scalar_i = '0;
    mdl_mask = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    chk(!busy_o && !issue_vld_o && !done_o, "R9", "outputs after reset",
        {busy_o, issue_vld_o, done_o}, 3'b000);
    do_run(64, 1'b0, 1'b1, 1'b0, 1'b0, "R9");      // all write-enables low: mask cleared

    // R2/R3: alternating mask, write-suppress, full length
    sc = 8'h5A;
    for (int i = 0; i < VL; i++) el[i*EW +: EW] = (i % 2 == 0) ? sc : 8'h11;
    load_mask(el, sc);
    do_run(64, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    do_run(64, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    do_run(10, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
    do_run(0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    do_run(100, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    do_run(20, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    do_run(1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");

    // all-zero mask in density mode: done straight away
    load_mask({VL{8'h33}}, 8'h33);
    do_run(64, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    do_run(64, 1'b0, 1'b1, 1'b0, 1'b0, "R3");

    // all-one mask
    load_mask({VL{8'h01}}, 8'h02);
    do_run(64, 1'b1, 1'b1, 1'b0, 1'b0, "R4");

    // R7: start during a run; R8: compare-load during a run
    load_mask(gen_elems(8'hC3, 50), 8'hC3);
    do_run(30, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    do_run(30, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
    do_run(64, 1'b0, 1'b1, 1'b0, 1'b0, "R8");       // mask unchanged by the ignored load

    // random mix
    for (int r = 0; r < 40; r++) begin
      if (r % 3 == 0) begin
        sc = EW'($urandom);
        load_mask(gen_elems(sc, int'($urandom % 101)), sc);
      end
      do_run(int'($urandom % 80), 1'($urandom), 1'($urandom), 1'b0, 1'b0,
             (r % 2 == 0) ? "R3" : "R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule